// File: doc/BRIEF.md
# Per-Stream Ingress Filter and Policer

This block decides, for every frame entering a switch port, whether the frame may go on toward an egress queue. Each frame arrives with a stream handle, its length in bytes and the queue it asks for. The handle has already been resolved upstream, and one handle value stands for "no known stream". The block looks up that stream's gate setting and its token bucket. It then produces a single registered decision: pass or drop, a reason code, and the queue the frame will actually use.

A stream whose gate is closed is dropped outright. An open stream must have enough bytes in its bucket to cover the frame. Frames from the unknown handle are never allowed into a critical queue. Depending on a configuration bit, such a frame is either moved to the best-effort queue or dropped. Every drop is counted against its stream and its reason, in saturating counters that software reads through a handle-indexed read port and clears one stream at a time.

Top module: `stream_ingress_policer`

## Requirements
- R1: The decision (`dec_valid` high with `dec_pass`, `dec_reason`, `dec_queue`) appears exactly one clock after the cycle in which `frm_valid` is high, and `dec_valid` is low in every cycle that does not follow a frame.
- R2: Reason codes are 0 = passed, 1 = policing (meter) violation, 2 = gate closed, 3 = other (unknown stream refused); `dec_pass` is 1 exactly when the reason is 0.
- R3: A frame whose stream has `cfg_gate_open[handle]` = 0 is dropped with reason 2 whatever its bucket holds, and it removes no bytes from that bucket.
- R4: A frame on an open gate passes the meter only when the stream's bucket holds at least `frm_len` bytes (equality passes); a passing frame removes `frm_len` bytes, and a refused frame removes none.
- R5: Every `CLKS_PER_US` clocks each bucket gains its stream's rate field of bytes, never exceeding its burst field; out of reset every bucket is full to its burst value.
- R6: Handle 15 denotes an unknown stream. When such a frame passes gate and meter but targets a queue whose bit is set in `CRIT_MASK` (queues 6 and 7 by default), it passes on queue `BE_QUEUE` (0) if `cfg_unk_drop` = 0. It is dropped with reason 3 if `cfg_unk_drop` = 1, and that drop removes no bytes.
- R7: A passing frame keeps its requested queue, except for the demotion of R6; unknown frames aimed at non-critical queues keep their queue.
- R8: Each stream has three drop counters (policing, gate closed, other); the counter matching a dropped frame's stream and reason rises by one at the same edge that registers the decision. `rd_police`, `rd_gate` and `rd_other` show the counters of stream `rd_handle`.
- R9: The counters are `CNT_W` bits wide (32 by default) and hold at their all-ones value instead of wrapping.
- R10: `cnt_clear[s]` zeroes all three counters of stream s at the next edge, takes precedence over an increment in the same cycle, and leaves other streams untouched.
- R11: After reset no decision is presented and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | Frame descriptor strobe, one cycle per frame |
| frm_handle | input | SH_W (4) | Stream handle; 15 means unknown stream |
| frm_len | input | LEN_W (16) | Frame length in bytes |
| frm_queue | input | QW (3) | Requested egress queue |
| cfg_gate_open | input | NS (16) | Per-stream gate, 1 = allow |
| cfg_rate | input | NS*RATE_W (256) | Per-stream refill bytes per microsecond, stream s at bits [s*RATE_W +: RATE_W] |
| cfg_burst | input | NS*BKT_W (320) | Per-stream bucket capacity in bytes, stream s at bits [s*BKT_W +: BKT_W] |
| cfg_unk_drop | input | 1 | 1 = drop unknown frames aimed at critical queues, 0 = demote them |
| cnt_clear | input | NS (16) | Per-stream counter clear strobe |
| rd_handle | input | SH_W (4) | Stream whose counters are shown on the read port |
| dec_valid | output | 1 | Decision strobe |
| dec_pass | output | 1 | 1 = frame admitted |
| dec_reason | output | 2 | Reason code (R2) |
| dec_queue | output | QW (3) | Queue the admitted frame uses |
| rd_police | output | CNT_W (32) | Policing drop count of `rd_handle` |
| rd_gate | output | CNT_W (32) | Gate-closed drop count of `rd_handle` |
| rd_other | output | CNT_W (32) | Other drop count of `rd_handle` |

## Verification
The assertions take for granted that reset is held for at least two clocks, so the counters already read zero when the first clock after reset compares against the previous one. They also assume that `rd_handle` and `cnt_clear` are ordinary synchronous inputs, so a counter may be judged monotonic only while the read handle is steady and no clear was pending. The stimulus keeps reset low for several cycles and changes all inputs only on the falling edge. It raises clear strobes only in cycles that are deliberately tested, and it never drives a handle outside 0 to 15. Most streams run with a zero refill rate, so the bucket levels stay exact. The one stream that refills is only checked with margins wider than one refill step.

// File: rtl/sip_pkg.sv
// Package: shared decision types for the per-stream ingress policer.
// Assumes: nothing; pure type definitions.
package sip_pkg;
    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_POLICE = 2'd1,
        RSN_GATE   = 2'd2,
        RSN_OTHER  = 2'd3
    } reason_e;
endpackage

// File: rtl/sip_us_tick.sv
// Module: free-running prescaler that emits one pulse every CLKS_PER_US clocks.
// Assumes: CLKS_PER_US >= 1; the count restarts from zero when reset is released.
module sip_us_tick #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(CLKS_PER_US + 1);

    logic [CW-1:0] cnt_q;

    // Pulse on the last count of each period.
    assign tick = (cnt_q == CW'(CLKS_PER_US - 1));

    // Advance the prescaler and wrap after the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sip_bucket.sv
// Module: one stream's token bucket in bytes.
// Assumes: BKT_W >= LEN_W and BKT_W >= RATE_W; commit is only raised when conform is high.
// The stored level may exceed burst (after reset or a burst reduction); it is
// clamped to burst before every use.
module sip_bucket #(
    parameter int LEN_W  = 16,
    parameter int RATE_W = 16,
    parameter int BKT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              commit,
    input  logic [LEN_W-1:0]  len,
    input  logic [RATE_W-1:0] rate,
    input  logic [BKT_W-1:0]  burst,
    output logic              conform
);
    logic [BKT_W-1:0] lvl_q;
    logic [BKT_W-1:0] lvl_eff;
    logic [BKT_W-1:0] after_use;
    logic [BKT_W:0]   refilled;
    logic [BKT_W-1:0] lvl_d;

    // Clamp, test the frame, deduct an admitted frame, then apply the refill.
    always_comb begin
        lvl_eff   = (lvl_q > burst) ? burst : lvl_q;
        conform   = (BKT_W'(len) <= lvl_eff);
        after_use = commit ? (lvl_eff - BKT_W'(len)) : lvl_eff;
        refilled  = {1'b0, after_use} + (BKT_W + 1)'(rate);
        if (tick)
            lvl_d = (refilled > {1'b0, burst}) ? burst : refilled[BKT_W-1:0];
        else
            lvl_d = after_use;
    end

    // Hold the level; reset to all ones so the clamp yields a full bucket.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/sip_drop_counters.sv
// Module: three saturating drop counters for one stream (policing, gate, other).
// Assumes: at most one increment per cycle; clear wins over increment.
module sip_drop_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [2:0]       inc,
    output logic [CNT_W-1:0] cnt_police,
    output logic [CNT_W-1:0] cnt_gate,
    output logic [CNT_W-1:0] cnt_other
);
    logic [CNT_W-1:0] cnt_q [3];

    for (genvar k = 0; k < 3; k++) begin : g_cnt
        // Count one event, hold at all ones, zero on clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt_q[k] <= '0;
            else if (inc[k] && (cnt_q[k] != '1))
                cnt_q[k] <= cnt_q[k] + 1'b1;
        end
    end

    assign cnt_police = cnt_q[0];
    assign cnt_gate   = cnt_q[1];
    assign cnt_other  = cnt_q[2];
endmodule

// File: rtl/stream_ingress_policer.sv
// Module: per-stream ingress gate, token-bucket meter and unknown-stream rule,
// with one registered decision per frame and per-stream, per-reason drop counters.
// Assumes: one frame descriptor per strobe; handle NS-1 is the unknown stream;
// configuration inputs are quasi-static and change only between frames.
module stream_ingress_policer
    import sip_pkg::*;
#(
    parameter int             NS          = 16,
    parameter int             LEN_W       = 16,
    parameter int             RATE_W      = 16,
    parameter int             BKT_W       = 20,
    parameter int             CNT_W       = 32,
    parameter int             QW          = 3,
    parameter int             CLKS_PER_US = 100,
    parameter logic [2**QW-1:0] CRIT_MASK = 8'hC0,
    parameter logic [QW-1:0]  BE_QUEUE    = '0,
    localparam int            SH_W        = $clog2(NS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic [SH_W-1:0]      frm_handle,
    input  logic [LEN_W-1:0]     frm_len,
    input  logic [QW-1:0]        frm_queue,
    input  logic [NS-1:0]        cfg_gate_open,
    input  logic [NS*RATE_W-1:0] cfg_rate,
    input  logic [NS*BKT_W-1:0]  cfg_burst,
    input  logic                 cfg_unk_drop,
    input  logic [NS-1:0]        cnt_clear,
    input  logic [SH_W-1:0]      rd_handle,
    output logic                 dec_valid,
    output logic                 dec_pass,
    output logic [1:0]           dec_reason,
    output logic [QW-1:0]        dec_queue,
    output logic [CNT_W-1:0]     rd_police,
    output logic [CNT_W-1:0]     rd_gate,
    output logic [CNT_W-1:0]     rd_other
);
    localparam logic [SH_W-1:0] UNK_HANDLE = SH_W'(NS - 1);

    logic             us_tick;
    logic [NS-1:0]    conform;
    logic             gate_ok, meter_ok, is_unk, is_crit, pass_c;
    reason_e          rsn_c;
    logic [QW-1:0]    queue_c;
    logic [CNT_W-1:0] pol_a [NS];
    logic [CNT_W-1:0] gat_a [NS];
    logic [CNT_W-1:0] oth_a [NS];

    sip_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick)
    );

    // Resolve the frame: gate first, then meter, then the unknown-stream rule.
    always_comb begin
        gate_ok  = cfg_gate_open[frm_handle];
        meter_ok = conform[frm_handle];
        is_unk   = (frm_handle == UNK_HANDLE);
        is_crit  = CRIT_MASK[frm_queue];
        rsn_c    = RSN_NONE;
        queue_c  = frm_queue;
        if (!gate_ok)
            rsn_c = RSN_GATE;
        else if (!meter_ok)
            rsn_c = RSN_POLICE;
        else if (is_unk && is_crit) begin
            if (cfg_unk_drop) rsn_c   = RSN_OTHER;
            else              queue_c = BE_QUEUE;
        end
        pass_c = (rsn_c == RSN_NONE);
    end

    for (genvar s = 0; s < NS; s++) begin : g_stream
        logic       hit;
        logic [2:0] inc;

        assign hit = frm_valid && (frm_handle == SH_W'(s));
        assign inc = {hit && (rsn_c == RSN_OTHER),
                      hit && (rsn_c == RSN_GATE),
                      hit && (rsn_c == RSN_POLICE)};

        sip_bucket #(.LEN_W(LEN_W), .RATE_W(RATE_W), .BKT_W(BKT_W)) u_bucket (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (us_tick),
            .commit  (hit && pass_c),
            .len     (frm_len),
            .rate    (cfg_rate[s*RATE_W +: RATE_W]),
            .burst   (cfg_burst[s*BKT_W +: BKT_W]),
            .conform (conform[s])
        );

        sip_drop_counters #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (cnt_clear[s]),
            .inc        (inc),
            .cnt_police (pol_a[s]),
            .cnt_gate   (gat_a[s]),
            .cnt_other  (oth_a[s])
        );
    end

    // Register the decision one cycle after the frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_pass   <= 1'b0;
            dec_reason <= RSN_NONE;
            dec_queue  <= '0;
        end else begin
            dec_valid  <= frm_valid;
            dec_pass   <= frm_valid && pass_c;
            dec_reason <= frm_valid ? rsn_c : RSN_NONE;
            dec_queue  <= queue_c;
        end
    end

    // Present the selected stream's counters on the read port.
    assign rd_police = pol_a[rd_handle];
    assign rd_gate   = gat_a[rd_handle];
    assign rd_other  = oth_a[rd_handle];
endmodule

// File: rtl/sip_checker.sv
// Module: temporal checks on the policer's ports, bound into every instance.
// Assumes: reset is held for at least two clocks before release.
module sip_checker #(
    parameter int             NS        = 16,
    parameter int             QW        = 3,
    parameter int             CNT_W     = 32,
    parameter logic [2**QW-1:0] CRIT_MASK = 8'hC0,
    localparam int            SH_W      = $clog2(NS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic [SH_W-1:0]  frm_handle,
    input logic [NS-1:0]    cfg_gate_open,
    input logic [NS-1:0]    cnt_clear,
    input logic [SH_W-1:0]  rd_handle,
    input logic             dec_valid,
    input logic             dec_pass,
    input logic [1:0]       dec_reason,
    input logic [QW-1:0]    dec_queue,
    input logic [CNT_W-1:0] rd_gate
);
    assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> dec_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !dec_valid);

    assert_pass_reason_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_pass == (dec_reason == 2'd0)));

    assert_gate_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !cfg_gate_open[frm_handle]) |=>
            (!dec_pass && dec_reason == 2'd2));

    assert_unknown_not_critical_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_pass && $past(frm_handle) == SH_W'(NS - 1)) |->
            !CRIT_MASK[dec_queue]);

    assert_counter_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_handle) && !$past(cnt_clear[rd_handle])) |->
            (rd_gate >= $past(rd_gate)));
endmodule

bind stream_ingress_policer sip_checker #(
    .NS(NS), .QW(QW), .CNT_W(CNT_W), .CRIT_MASK(CRIT_MASK)
) u_sip_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_valid     (frm_valid),
    .frm_handle    (frm_handle),
    .cfg_gate_open (cfg_gate_open),
    .cnt_clear     (cnt_clear),
    .rd_handle     (rd_handle),
    .dec_valid     (dec_valid),
    .dec_pass      (dec_pass),
    .dec_reason    (dec_reason),
    .dec_queue     (dec_queue),
    .rd_gate       (rd_gate)
);

// File: tb/stream_ingress_policer_test.sv
module stream_ingress_policer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS     = 16;
    localparam int LEN_W  = 16;
    localparam int RATE_W = 16;
    localparam int BKT_W  = 20;
    localparam int CNT_W  = 4;
    localparam int QW     = 3;
    localparam int TICK   = 10;
    localparam int NVEC   = 10;

    // {handle[4], len[16], queue[3], exp_pass[1], exp_reason[2], exp_queue[3]}
    localparam logic [28:0] VEC [NVEC] = '{
        {4'd0,  16'd400, 3'd6, 1'b1, 2'd0, 3'd6},
        {4'd0,  16'd600, 3'd7, 1'b1, 2'd0, 3'd7},
        {4'd0,  16'd1,   3'd6, 1'b0, 2'd1, 3'd0},
        {4'd1,  16'd64,  3'd5, 1'b0, 2'd2, 3'd0},
        {4'd1,  16'd64,  3'd5, 1'b0, 2'd2, 3'd0},
        {4'd15, 16'd100, 3'd7, 1'b1, 2'd0, 3'd0},
        {4'd15, 16'd100, 3'd3, 1'b1, 2'd0, 3'd3},
        {4'd2,  16'd499, 3'd4, 1'b1, 2'd0, 3'd4},
        {4'd2,  16'd2,   3'd4, 1'b0, 2'd1, 3'd0},
        {4'd2,  16'd1,   3'd4, 1'b1, 2'd0, 3'd4}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frm_valid = 1'b0;
    logic [3:0]           frm_handle = '0;
    logic [LEN_W-1:0]     frm_len = '0;
    logic [QW-1:0]        frm_queue = '0;
    logic [NS-1:0]        cfg_gate_open = '0;
    logic [NS*RATE_W-1:0] cfg_rate = '0;
    logic [NS*BKT_W-1:0]  cfg_burst = '0;
    logic                 cfg_unk_drop = 1'b0;
    logic [NS-1:0]        cnt_clear = '0;
    logic [3:0]           rd_handle = '0;
    logic                 dec_valid, dec_pass;
    logic [1:0]           dec_reason;
    logic [QW-1:0]        dec_queue;
    logic [CNT_W-1:0]     rd_police, rd_gate, rd_other;

    int n_chk = 0;
    int n_fail = 0;

    stream_ingress_policer #(
        .NS(NS), .LEN_W(LEN_W), .RATE_W(RATE_W), .BKT_W(BKT_W), .CNT_W(CNT_W),
        .QW(QW), .CLKS_PER_US(TICK), .CRIT_MASK(8'hC0), .BE_QUEUE(3'd0)
    ) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_stream(input int s, input logic g, input int r, input int b);
        cfg_gate_open[s] = g;
        cfg_rate[s*RATE_W +: RATE_W] = RATE_W'(r);
        cfg_burst[s*BKT_W +: BKT_W]  = BKT_W'(b);
    endtask

    task automatic drive(input int h, input int len, input int q);
        frm_valid  = 1'b1;
        frm_handle = 4'(h);
        frm_len    = LEN_W'(len);
        frm_queue  = QW'(q);
    endtask

    task automatic idle();
        frm_valid = 1'b0;
    endtask

    // Wait one clock and compare the registered decision.
    task automatic expect_dec(input string tag, input logic p, input int r, input int q);
        @(negedge clk);
        chk(tag, "dec_valid", 32'(dec_valid), 32'd1);
        chk(tag, "dec_pass", 32'(dec_pass), 32'(p));
        chk(tag, "dec_reason", 32'(dec_reason), 32'(r));
        if (p) chk(tag, "dec_queue", 32'(dec_queue), 32'(q));
    endtask

    task automatic expect_cnt(input string tag, input int h, input int ep, input int eg, input int eo);
        rd_handle = 4'(h);
        #1;
        chk(tag, "rd_police", 32'(rd_police), 32'(ep));
        chk(tag, "rd_gate", 32'(rd_gate), 32'(eg));
        chk(tag, "rd_other", 32'(rd_other), 32'(eo));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        set_stream(0, 1'b1, 0, 1000);
        set_stream(1, 1'b0, 0, 0);
        set_stream(2, 1'b1, 0, 500);
        set_stream(3, 1'b0, 0, 500);
        set_stream(4, 1'b1, 100, 1000);
        set_stream(15, 1'b1, 0, 4000);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: no decision and zero counters after reset
        chk("R11", "dec_valid after reset", 32'(dec_valid), 32'd0);
        expect_cnt("R11", 0, 0, 0, 0);
        expect_cnt("R11", 15, 0, 0, 0);

        // Vector table: R4 exact boundary, R3 gate priority, R6/R7 unknown demotion
        for (int i = 0; i < NVEC; i++) begin
            drive(int'(VEC[i][28:25]), int'(VEC[i][24:9]), int'(VEC[i][8:6]));
            expect_dec($sformatf("R4/R3/R6/R7 vec%0d", i), VEC[i][5],
                       int'(VEC[i][4:3]), int'(VEC[i][2:0]));
        end
        idle();
        @(negedge clk);
        chk("R1", "dec_valid idle", 32'(dec_valid), 32'd0);

        // R8: per-stream, per-reason attribution
        expect_cnt("R8", 0, 1, 0, 0);
        expect_cnt("R8", 1, 0, 2, 0);
        expect_cnt("R8", 2, 1, 0, 0);
        expect_cnt("R8", 15, 0, 0, 0);

        // R3: a gate drop consumes no tokens
        drive(3, 400, 2);
        expect_dec("R3 closed", 1'b0, 2, 0);
        cfg_gate_open[3] = 1'b1;
        drive(3, 400, 2);
        expect_dec("R3 full after gate drop", 1'b1, 0, 2);
        drive(3, 200, 2);
        expect_dec("R4 short", 1'b0, 1, 0);
        drive(3, 100, 2);
        expect_dec("R4 equal", 1'b1, 0, 2);
        idle();

        // R6: unknown critical drop mode, no tokens taken by that drop
        cfg_unk_drop = 1'b1;
        drive(15, 3000, 7);
        expect_dec("R6 drop", 1'b0, 3, 0);
        drive(15, 3000, 2);
        expect_dec("R6 no consume", 1'b1, 0, 2);
        drive(15, 900, 2);
        expect_dec("R4 unknown metered", 1'b0, 1, 0);
        idle();
        @(negedge clk);
        expect_cnt("R8 R6", 15, 1, 0, 1);

        // R5: refill at the configured rate, capped at burst
        drive(4, 1000, 1);
        expect_dec("R5 full", 1'b1, 0, 1);
        drive(4, 250, 1);
        expect_dec("R5 drained", 1'b0, 1, 0);
        idle();
        repeat (3 * TICK) @(negedge clk);
        drive(4, 300, 1);
        expect_dec("R5 refilled", 1'b1, 0, 1);
        idle();
        repeat (20 * TICK) @(negedge clk);
        drive(4, 1000, 1);
        expect_dec("R5 capped full", 1'b1, 0, 1);
        drive(4, 101, 1);
        expect_dec("R5 cap", 1'b0, 1, 0);
        idle();

        // R9: saturation at all ones
        for (int k = 0; k < 20; k++) begin
            drive(1, 64, 0);
            expect_dec("R9 gate burst", 1'b0, 2, 0);
        end
        idle();
        @(negedge clk);
        expect_cnt("R9", 1, 0, (1 << CNT_W) - 1, 0);

        // R10: clear is per stream and beats a same-cycle increment
        cnt_clear = 16'h0002;
        drive(1, 64, 0);
        @(negedge clk);
        cnt_clear = '0;
        idle();
        expect_cnt("R10 cleared", 1, 0, 0, 0);
        expect_cnt("R10 others kept", 0, 1, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule